// File: doc/BRIEF.md
# Opcode-Driven Shift Register

This block holds an 8-bit word in a register and, on every rising clock edge, replaces it with a new value chosen by a 3-bit operation code. The code can clear the word, load a fresh value from the data input, hold it, shift it one place by arithmetic rules, or rotate it one place in either direction. The output is always the registered word. Nothing changes between edges.

The opcodes act as the named states of the update machine. CLEAR (000) zeroes the word. SHR_ARITH (001) shifts right and keeps the sign bit. SHL_ARITH (010) shifts left and fills with zero. ROT_RIGHT (011) and ROT_LEFT (100) rotate by one place. KEEP (101) and IDLE (111) hold the word. LOAD (110) takes the data input. Every state can move to any other state on the next edge, because the transition is simply the opcode that is present at that edge. Each bit of the register is built as an eight-way selector in front of a flip-flop. All slices share one candidate builder, which computes the eight possible next words.

An asynchronous active-high reset forces the word to zero at any time.

Top module: `opshift_reg`

## Requirements
- R1: While `rst` is high, `q_out` is 0 whatever the clock and the opcode do. The reset takes effect without waiting for a clock edge.
- R2: Opcode 000 sets all bits of `q_out` to 0 at the next rising edge.
- R3: Opcode 001 moves each bit one place toward bit 0. Bit 7 keeps its old value, so the sign of the word is kept.
- R4: Opcode 010 moves each bit one place toward bit 7, and bit 0 becomes 0.
- R5: Opcode 011 moves each bit one place toward bit 0, and the old bit 0 becomes the new bit 7.
- R6: Opcode 100 moves each bit one place toward bit 7, and the old bit 7 becomes the new bit 0.
- R7: Opcode 101 leaves `q_out` unchanged across the edge.
- R8: Opcode 110 copies `data_in` into the register at the next rising edge.
- R9: Opcode 111 leaves `q_out` unchanged across the edge.
- R10: Under every opcode except 110, the value on `data_in` has no effect on the next `q_out`.
- R11: `q_out` changes only at a rising clock edge, or when reset is applied. A change of `op_code` or `data_in` between edges leaves it as it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Update clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high, clears the word |
| op_code | input | 3 | Operation applied at the next rising edge |
| data_in | input | 8 | Value taken by the load operation |
| q_out | output | 8 | Registered word |

## Verification
The embedded properties check on every edge that the new word matches the operation applied to the previous word, for each of the eight codes. They also check that the word is zero while reset is high. Only the bench scenarios can show the effects that depend on time and on sequences of operations:
- the asynchronous reset acting between edges,
- the word staying steady when the inputs move in the middle of a cycle,
- the sign being kept over repeated arithmetic right shifts,
- a full rotation returning the original word,
- junk on `data_in` leaving every operation except load unaffected.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

    localparam int OP_BITS  = 3;
    localparam int OP_COUNT = 1 << OP_BITS;

    // Encoding is behaviour: these values are the opcode pins.
    typedef enum logic [OP_BITS-1:0] {
        CLEAR     = 3'b000,
        SHR_ARITH = 3'b001,
        SHL_ARITH = 3'b010,
        ROT_RIGHT = 3'b011,
        ROT_LEFT  = 3'b100,
        KEEP      = 3'b101,
        LOAD      = 3'b110,
        IDLE      = 3'b111
    } shop_e;

endpackage

// File: rtl/opshift_cands.sv
module opshift_cands
    import opshift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]                q_cur,
    input  logic [WIDTH-1:0]                d_in,
    output logic [OP_COUNT-1:0][WIDTH-1:0]  cand
);

    localparam int MSB = WIDTH - 1;

    // One candidate next word per opcode state.
    always_comb begin
        for (int k = 0; k < OP_COUNT; k++) begin
            unique case (shop_e'(k[OP_BITS-1:0]))
                CLEAR:     cand[k] = '0;
                SHR_ARITH: cand[k] = {q_cur[MSB], q_cur[MSB:1]};
                SHL_ARITH: cand[k] = {q_cur[MSB-1:0], 1'b0};
                ROT_RIGHT: cand[k] = {q_cur[0], q_cur[MSB:1]};
                ROT_LEFT:  cand[k] = {q_cur[MSB-1:0], q_cur[MSB]};
                KEEP:      cand[k] = q_cur;
                LOAD:      cand[k] = d_in;
                IDLE:      cand[k] = q_cur;
                default:   cand[k] = q_cur;
            endcase
        end
    end

endmodule

// File: rtl/opshift_slice.sv
module opshift_slice
    import opshift_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [OP_BITS-1:0]  sel,
    input  logic [OP_COUNT-1:0] pick,
    output logic                bit_q
);

    logic bit_d;

    // Eight-way selector in front of the flop.
    always_comb bit_d = pick[sel];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= bit_d;
    end

endmodule

// File: rtl/opshift_reg.sv
module opshift_reg
    import opshift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op_code,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] q_out
);

    localparam int MSB = WIDTH - 1;

    logic [OP_COUNT-1:0][WIDTH-1:0] cand;
    logic [WIDTH-1:0]               q_int;

    opshift_cands #(.WIDTH(WIDTH)) u_cands (
        .q_cur (q_int),
        .d_in  (data_in),
        .cand  (cand)
    );

    // One slice per bit; candidates are transposed per bit.
    for (genvar b = 0; b < WIDTH; b++) begin : g_slice
        logic [OP_COUNT-1:0] pick_b;
        for (genvar k = 0; k < OP_COUNT; k++) begin : g_pick
            assign pick_b[k] = cand[k][b];
        end
        opshift_slice u_slice (
            .clk   (clk),
            .rst   (rst),
            .sel   (op_code),
            .pick  (pick_b),
            .bit_q (q_int[b])
        );
    end

    always_comb q_out = q_int;

    // Properties guarding the update machine.
    assert_reset_zero_R1: assert property (@(posedge clk) rst |-> q_out == '0);

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_code) == 3'b000) |-> q_out == '0);

    assert_shr_arith_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_code) == 3'b001)
        |-> q_out == {$past(q_out[MSB]), $past(q_out[MSB:1])});

    assert_shl_arith_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_code) == 3'b010)
        |-> q_out == {$past(q_out[MSB-1:0]), 1'b0});

    assert_rot_right_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_code) == 3'b011)
        |-> q_out == {$past(q_out[0]), $past(q_out[MSB:1])});

    assert_rot_left_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_code) == 3'b100)
        |-> q_out == {$past(q_out[MSB-1:0]), $past(q_out[MSB])});

    assert_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_code) == 3'b101) |-> $stable(q_out));

    assert_load_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_code) == 3'b110) |-> q_out == $past(data_in));

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_code) == 3'b111) |-> $stable(q_out));

endmodule

// File: tb/opshift_reg_test.sv
`timescale 1ns/1ps
module opshift_reg_test;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic [2:0] op_code = 3'b101;
    logic [7:0] data_in = 8'h00;
    logic [7:0] q_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    logic [7:0] model_q = 8'h00;

    always #10 clk = ~clk;   // 50 MHz

    opshift_reg uut (
        .clk     (clk),
        .rst     (rst),
        .op_code (op_code),
        .data_in (data_in),
        .q_out   (q_out)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] predict(input logic [2:0] op, input logic [7:0] q,
                                           input logic [7:0] d);
        case (op)
            3'b000:  return 8'h00;
            3'b001:  return {q[7], q[7:1]};
            3'b010:  return {q[6:0], 1'b0};
            3'b011:  return {q[0], q[7:1]};
            3'b100:  return {q[6:0], q[7]};
            3'b110:  return d;
            default: return q;
        endcase
    endfunction

    // Driver: apply at negedge, push the expected word.
    task automatic drive(input logic [2:0] op, input logic [7:0] d, input string req);
        @(negedge clk);
        op_code = op;
        data_in = d;
        model_q = predict(op, model_q, d);
        sb.push_back('{model_q, req});
    endtask

    // Monitor: compare just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(q_out, it.exp, it.req);
        end
    end

    initial begin
        #2 rst = 1'b1;
        #5;
        check(q_out, 8'h00, "R1 async");
        @(negedge clk); @(negedge clk);
        op_code = 3'b110; data_in = 8'hA5;
        @(posedge clk); #1;
        check(q_out, 8'h00, "R1 held");
        @(negedge clk);
        rst = 1'b0;
        model_q = 8'h00;

        drive(3'b110, 8'h96, "R8 load");
        drive(3'b001, 8'hFF, "R3 asr neg");
        drive(3'b001, 8'h00, "R3 asr neg2");
        drive(3'b110, 8'h4C, "R8 load pos");
        drive(3'b001, 8'hFF, "R3 asr pos R10");
        drive(3'b010, 8'hFF, "R4 asl R10");
        drive(3'b010, 8'h00, "R4 asl");
        drive(3'b110, 8'h81, "R8 load");
        drive(3'b011, 8'h7E, "R5 ror R10");
        drive(3'b011, 8'h00, "R5 ror");
        drive(3'b100, 8'hFF, "R6 rol R10");
        drive(3'b100, 8'h00, "R6 rol");
        drive(3'b101, 8'h3C, "R7 keep R10");
        drive(3'b111, 8'hC3, "R9 idle R10");
        for (int i = 0; i < 8; i++) drive(3'b100, 8'(i), "R6 full turn");
        drive(3'b101, 8'h00, "R7 keep after turn");
        for (int i = 0; i < 8; i++) drive(3'b011, 8'hAA, "R5 full turn");
        drive(3'b000, 8'hFF, "R2 clear R10");
        drive(3'b110, 8'h5A, "R8 load");
        wait (sb.size() == 0);

        // R11: inputs change mid-cycle, output must hold.
        @(negedge clk);
        op_code = 3'b111; data_in = 8'h00;
        @(posedge clk); #4;
        op_code = 3'b000; data_in = 8'hFF;
        #2;
        check(q_out, 8'h5A, "R11 mid-cycle");
        op_code = 3'b111;
        @(posedge clk); #1;
        check(q_out, 8'h5A, "R11 after edge");

        // R1 between edges.
        @(negedge clk); #3;
        rst = 1'b1;
        #1;
        check(q_out, 8'h00, "R1 mid-cycle");
        @(negedge clk);
        rst = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule